// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block turns memory requests from an 8-bit processor core into the strobe pattern of a multiplexed external bus. It runs on the oscillator clock. Each machine cycle is twelve clocks long: six states of two phases each. One free-running state counter times every strobe. At the last clock of each machine cycle the block raises `slot_open`. A request held on the core side at that clock becomes the operation for the next machine cycle. There are four request kinds: a code fetch, a code-table read, a data read and a data write. Read results come back on `rd_data` with a one-clock `rd_valid` at the final clock of the cycle.

On the pin side the low address byte and the data share one port (`ad_out`, `ad_oe`, `ad_in`), and a separate port carries the high address byte. An address-latch strobe pulses twice per machine cycle so that external logic can capture the low address. The block drops the second pulse in data cycles and can be told through a control register to pulse only when an external data or table access needs it. Code fetches use a two-pulse code-read strobe. The two data strobes are separate. A reset qualifier filters the raw reset input and drives `core_rst` for the core and for this block.

Top module: `ebus_seq`

## Requirements
- R1: A machine cycle lasts 12 clocks. Out of reset, `slot_open` is high for exactly the last clock of every machine cycle (positions numbered 0..11 from the first clock after the accepting edge).
- R2: With the latch-disable bit clear, in idle and code-fetch cycles `addr_latch` is high at positions 0,1 and 6,7 (two pulses, one every six clocks). While it is high, no read or write strobe is low.
- R3: In a data read or data write cycle, `addr_latch` is high only at positions 0,1 and `code_rd_n` stays high for the whole cycle.
- R4: An external code fetch drives `code_rd_n` low at positions 2-4 and 8-10. `ad_out` carries the request address low byte at positions 0,1 and the address-plus-one low byte at positions 6,7, with `ad_oe` high only at those four positions. The high port carries the matching high bytes for the first and second half of the cycle.
- R5: A fetch or table read samples `ad_in` on each rising edge of `code_rd_n`. It returns `rd_data` = {second byte, first byte} with `rd_valid` high only at position 11.
- R6: A code fetch goes to the bus when `force_ext_n` is low, for any address. When `force_ext_n` is high and the address is below `INT_CODE_BYTES` (8192), the cycle makes no code-read pulse and no `rd_valid`. When `force_ext_n` is high and the address is at or above 8192, the fetch goes to the bus.
- R7: A data read drives `data_rd_n` low at positions 2-9 with `ad_oe` low throughout. It samples `ad_in` on the rising edge of `data_rd_n` and returns `rd_data` = {8'h00, byte} with `rd_valid` at position 11.
- R8: A data write keeps `ad_oe` high at all 12 positions and drives `data_wr_n` low at positions 3-9. Whenever `data_wr_n` is low, `ad_out` equals the write data.
- R9: In a data cycle with `req_wide`=1 the high port carries the address high byte for the whole cycle. With `req_wide`=0 it carries `hi_latch`.
- R10: Bit 0 of the control register at address 8'h8E is the latch-disable bit. When it is set, idle and code-fetch cycles produce no `addr_latch` pulse. Table reads keep both pulses and data cycles keep the first. A control write to any other address leaves the bit unchanged.
- R11: `core_rst` rises only after `reset_in` has been sampled high on more than 24 consecutive clocks, so a 24-clock pulse changes nothing. `core_rst` falls once `reset_in` is seen low.
- R12: While `core_rst` is high, all strobes are inactive and the shared port is released. Reset also clears the latch-disable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| reset_in | input | 1 | Raw reset input, active high |
| force_ext_n | input | 1 | Low: every code fetch uses the external bus |
| req_valid | input | 1 | Request present, taken while `slot_open` is high |
| req_op | input | 2 | 0 fetch, 1 table read, 2 data read, 3 data write |
| req_addr | input | 16 | Request address |
| req_wide | input | 1 | Data cycles: 1 = 16-bit address, 0 = 8-bit address |
| req_wdata | input | 8 | Write data |
| hi_latch | input | 8 | High-port latch contents |
| ctl_we | input | 1 | Control register write strobe |
| ctl_addr | input | 8 | Control register address |
| ctl_wdata | input | 8 | Control register write data |
| slot_open | output | 1 | Last clock of the machine cycle |
| rd_valid | output | 1 | Read data valid, one clock |
| rd_data | output | 16 | Read data |
| core_rst | output | 1 | Qualified reset |
| addr_latch | output | 1 | Address latch strobe, active high |
| code_rd_n | output | 1 | External code read strobe, active low |
| data_rd_n | output | 1 | External data read strobe, active low |
| data_wr_n | output | 1 | External data write strobe, active low |
| ad_out | output | 8 | Shared address/data port output |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input |
| hi_out | output | 8 | High address port |

## Verification
Every strobe depends on the state counter and the operation latched for the cycle. A counter off by even one clock therefore moves the twelve-position pulse masks and the `slot_open` position within the next machine cycle. A wrong operation kind or a stale latch-disable bit shows within the same cycle as an extra or missing address-latch pulse, a code-read pulse in a data cycle, or port drive during a read. A wrong sampling edge returns the filler byte the bench drives whenever no read strobe is active, so it shows in `rd_data` at position 11. A miscounting reset qualifier shows as `core_rst` rising during a 24-clock pulse, or not rising within a few clocks of the threshold.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [2:0] {
    CY_IDLE  = 3'd0,
    CY_FETCH = 3'd1,
    CY_TABLE = 3'd2,
    CY_DRD   = 3'd3,
    CY_DWR   = 3'd4
  } cyc_kind_t;

  localparam logic [1:0] OP_FETCH = 2'd0;
  localparam logic [1:0] OP_TABLE = 2'd1;
  localparam logic [1:0] OP_DRD   = 2'd2;
  localparam logic [1:0] OP_DWR   = 2'd3;

  typedef struct packed {
    cyc_kind_t   kind;
    logic        wide;
    logic [15:0] addr;
    logic [15:0] addr_nx;
    logic [7:0]  wdata;
  } cyc_t;
endpackage

// File: rtl/ebus_timer.sv
module ebus_timer #(
  parameter int CYC_CLKS = 12,
  localparam int CW = $clog2(CYC_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] nxt,
  output logic          slot_open
);
  localparam logic [CW-1:0] LAST = CW'(CYC_CLKS - 1);

  logic [CW-1:0] cnt    = LAST;
  logic          slot_q = 1'b0;

  always_comb nxt = (cnt == LAST) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= LAST;
      slot_q <= 1'b0;
    end else begin
      cnt    <= nxt;
      slot_q <= (nxt == LAST);
    end
  end

  assign slot_open = slot_q;

  // R1
  slot_single_chk: assert property (@(posedge clk) disable iff (rst)
    slot_open |=> !slot_open);
endmodule

// File: rtl/ebus_ctl.sv
module ebus_ctl #(
  parameter logic [7:0] CTL_ADDR = 8'h8E
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic       latch_off
);
  logic off_q = 1'b0;
  logic unused_ctl_bits;
  assign unused_ctl_bits = ^wdata[7:1];

  always_ff @(posedge clk) begin
    if (rst)                           off_q <= 1'b0;
    else if (we && addr == CTL_ADDR)   off_q <= wdata[0];
  end

  assign latch_off = off_q;

  // R10
  off_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == CTL_ADDR) |=> $stable(latch_off));
endmodule

// File: rtl/ebus_rst_qual.sv
module ebus_rst_qual #(
  parameter int HOLD = 25,
  localparam int HW = $clog2(HOLD)
) (
  input  logic clk,
  input  logic pin,
  output logic core_rst
);
  localparam logic [HW-1:0] TOP = HW'(HOLD - 1);

  logic [1:0]    sync_q = 2'b00;
  logic [HW-1:0] run    = '0;
  logic          rst_q  = 1'b0;
  logic          armed  = 1'b0;

  always_ff @(posedge clk) begin
    sync_q <= {sync_q[0], pin};
    armed  <= 1'b1;
    if (!sync_q[1]) begin
      run   <= '0;
      rst_q <= 1'b0;
    end else begin
      run   <= (run == TOP) ? run : run + 1'b1;
      rst_q <= (run == TOP);
    end
  end

  assign core_rst = rst_q;

  // R11
  rst_release_chk: assert property (@(posedge clk) disable iff (!armed)
    !sync_q[1] |=> !core_rst);
  // R11
  rst_needs_pin_chk: assert property (@(posedge clk) disable iff (!armed)
    $rose(core_rst) |-> $past(sync_q[1]));
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq import ebus_pkg::*; #(
  parameter int          STATES         = 6,
  parameter int          PHASES         = 2,
  parameter int unsigned INT_CODE_BYTES = 8192,
  parameter logic [7:0]  CTL_ADDR       = 8'h8E,
  parameter int          RST_CYCLES     = 2
) (
  input  logic        clk,
  input  logic        reset_in,
  input  logic        force_ext_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [15:0] req_addr,
  input  logic        req_wide,
  input  logic [7:0]  req_wdata,
  input  logic [7:0]  hi_latch,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_addr,
  input  logic [7:0]  ctl_wdata,
  output logic        slot_open,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic        core_rst,
  output logic        addr_latch,
  output logic        code_rd_n,
  output logic        data_rd_n,
  output logic        data_wr_n,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  input  logic [7:0]  ad_in,
  output logic [7:0]  hi_out
);
  localparam int CYC_CLKS = STATES * PHASES;
  localparam int HALF     = CYC_CLKS / 2;
  localparam int CW       = $clog2(CYC_CLKS);
  localparam logic [CW-1:0] S_PH     = CW'(PHASES);
  localparam logic [CW-1:0] S_HALF   = CW'(HALF);
  localparam logic [CW-1:0] S_HALFM1 = CW'(HALF - 1);
  localparam logic [CW-1:0] S_HALFM2 = CW'(HALF - 2);
  localparam logic [CW-1:0] S_BEND   = CW'(HALF + PHASES);
  localparam logic [CW-1:0] S_WRS    = CW'(PHASES + 1);
  localparam logic [CW-1:0] S_LAST   = CW'(CYC_CLKS - 1);
  localparam logic [CW-1:0] S_LASTM1 = CW'(CYC_CLKS - 2);
  localparam logic [CW-1:0] S_LASTM2 = CW'(CYC_CLKS - 3);

  logic [CW-1:0] n;
  logic          latch_off;

  ebus_rst_qual #(.HOLD(RST_CYCLES * CYC_CLKS + 1)) i_rstq (
    .clk(clk), .pin(reset_in), .core_rst(core_rst));

  ebus_timer #(.CYC_CLKS(CYC_CLKS)) i_timer (
    .clk(clk), .rst(core_rst), .nxt(n), .slot_open(slot_open));

  ebus_ctl #(.CTL_ADDR(CTL_ADDR)) i_ctl (
    .clk(clk), .rst(core_rst), .we(ctl_we), .addr(ctl_addr),
    .wdata(ctl_wdata), .latch_off(latch_off));

  // Operation for the clock being decoded: new request at position 0.
  cyc_t cur = '0;
  cyc_t inc, cn;
  logic ext_code;

  always_comb begin
    ext_code    = !force_ext_n || (32'(req_addr) >= INT_CODE_BYTES);
    inc         = '0;
    inc.addr    = req_addr;
    inc.addr_nx = req_addr + 16'd1;
    inc.wdata   = req_wdata;
    inc.wide    = req_wide;
    unique case (req_op)
      OP_FETCH: begin inc.kind = ext_code ? CY_FETCH : CY_IDLE; inc.wide = 1'b1; end
      OP_TABLE: begin inc.kind = ext_code ? CY_TABLE : CY_IDLE; inc.wide = 1'b1; end
      OP_DRD:   inc.kind = CY_DRD;
      default:  inc.kind = CY_DWR;
    endcase
    if (n == '0) cn = (slot_open && req_valid) ? inc : '0;
    else         cn = cur;
  end

  logic code_c, data_c, in_a, in_b, latch_ok;
  always_comb begin
    code_c   = (cn.kind == CY_FETCH) || (cn.kind == CY_TABLE);
    data_c   = (cn.kind == CY_DRD) || (cn.kind == CY_DWR);
    in_a     = (n < S_PH);
    in_b     = (n >= S_HALF) && (n < S_BEND);
    latch_ok = !latch_off || (cn.kind == CY_TABLE) || data_c;
  end

  logic        ale_q = 1'b0, crd_q = 1'b1, drd_q = 1'b1, dwr_q = 1'b1;
  logic        oe_q  = 1'b0, val_q = 1'b0;
  logic [7:0]  ado_q = '0,   hi_q  = 8'hFF;
  logic [15:0] rdd_q = '0;

  always_ff @(posedge clk) begin
    if (core_rst) begin
      cur   <= '0;
      ale_q <= 1'b0;
      crd_q <= 1'b1;
      drd_q <= 1'b1;
      dwr_q <= 1'b1;
      oe_q  <= 1'b0;
      val_q <= 1'b0;
      ado_q <= '0;
      hi_q  <= 8'hFF;
    end else begin
      cur   <= cn;
      ale_q <= latch_ok && (in_a || (in_b && !data_c));
      crd_q <= !(code_c && ((n >= S_PH && n <= S_HALFM2) ||
                            (n >= S_BEND && n <= S_LASTM1)));
      drd_q <= !(cn.kind == CY_DRD && n >= S_PH && n <= S_LASTM2);
      dwr_q <= !(cn.kind == CY_DWR && n >= S_WRS && n <= S_LASTM2);
      oe_q  <= (code_c && (in_a || in_b)) || (cn.kind == CY_DRD && in_a) ||
               (cn.kind == CY_DWR);
      if (in_a)                 ado_q <= cn.addr[7:0];
      else if (code_c && in_b)  ado_q <= cn.addr_nx[7:0];
      else if (cn.kind == CY_DWR) ado_q <= cn.wdata;
      if (code_c)               hi_q <= (n < S_HALF) ? cn.addr[15:8] : cn.addr_nx[15:8];
      else if (data_c && cn.wide) hi_q <= cn.addr[15:8];
      else                      hi_q <= hi_latch;
      if (code_c && n == S_HALFM1)        rdd_q[7:0]  <= ad_in;
      if (code_c && n == S_LAST)          rdd_q[15:8] <= ad_in;
      if (cn.kind == CY_DRD && n == S_LASTM1) rdd_q   <= {8'h00, ad_in};
      val_q <= (n == S_LAST) && (code_c || cn.kind == CY_DRD);
    end
  end

  assign addr_latch = ale_q;
  assign code_rd_n  = crd_q;
  assign data_rd_n  = drd_q;
  assign data_wr_n  = dwr_q;
  assign ad_oe      = oe_q;
  assign ad_out     = ado_q;
  assign hi_out     = hi_q;
  assign rd_data    = rdd_q;
  assign rd_valid   = val_q;

  // R2
  latch_apart_chk: assert property (@(posedge clk) disable iff (core_rst)
    addr_latch |-> (code_rd_n && data_rd_n && data_wr_n));
  // R3
  code_data_excl_chk: assert property (@(posedge clk) disable iff (core_rst)
    !data_rd_n |-> code_rd_n);
  // R5
  valid_one_chk: assert property (@(posedge clk) disable iff (core_rst)
    rd_valid |=> !rd_valid);
  // R1
  valid_at_end_chk: assert property (@(posedge clk) disable iff (core_rst)
    rd_valid |-> slot_open);
  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (core_rst)
    !data_rd_n |-> !ad_oe);
  // R8
  write_drive_chk: assert property (@(posedge clk) disable iff (core_rst)
    !data_wr_n |-> ad_oe);
  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    core_rst |=> (code_rd_n && data_rd_n && data_wr_n && !ad_oe));
endmodule

// File: tb/test_ebus_seq.sv
module test_ebus_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        reset_in = 1'b1, force_ext_n = 1'b0, req_valid = 1'b0, req_wide = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, hi_latch = 8'hA5, ctl_addr = '0, ctl_wdata = '0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ad_in = 8'hEE;
  logic        slot_open, rd_valid, core_rst, addr_latch, code_rd_n, data_rd_n, data_wr_n, ad_oe;
  logic [15:0] rd_data;
  logic [7:0]  ad_out, hi_out;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ebus_seq i_ebus_seq (
    .clk(clk), .reset_in(reset_in), .force_ext_n(force_ext_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wide(req_wide), .req_wdata(req_wdata), .hi_latch(hi_latch),
    .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .slot_open(slot_open), .rd_valid(rd_valid), .rd_data(rd_data),
    .core_rst(core_rst), .addr_latch(addr_latch), .code_rd_n(code_rd_n),
    .data_rd_n(data_rd_n), .data_wr_n(data_wr_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .hi_out(hi_out));

  // masks: bit i = strobe active at position i of the cycle
  logic [11:0] m_ale, m_crd, m_drd, m_dwr, m_oe, m_val, m_slot;
  logic [7:0]  ad0, ad6, hi0, hi6;
  logic [15:0] rdat;
  int          wr_bad;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run_cycle(input bit is_req, input logic [1:0] op, input logic [15:0] a,
                           input logic wide, input logic [7:0] wd,
                           input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk);
    while (!slot_open) @(negedge clk);
    req_valid = is_req; req_op = op; req_addr = a; req_wide = wide; req_wdata = wd;
    m_ale = '0; m_crd = '0; m_drd = '0; m_dwr = '0; m_oe = '0; m_val = '0; m_slot = '0;
    wr_bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      m_ale[i] = addr_latch;  m_crd[i] = !code_rd_n; m_drd[i] = !data_rd_n;
      m_dwr[i] = !data_wr_n;  m_oe[i]  = ad_oe;      m_val[i] = rd_valid;
      m_slot[i] = slot_open;
      if (i == 0) begin ad0 = ad_out; hi0 = hi_out; req_valid = 1'b0; end
      if (i == 6) begin ad6 = ad_out; hi6 = hi_out; end
      if (!data_wr_n && !(ad_oe && ad_out == wd)) wr_bad++;
      if (i == 11) rdat = rd_data;
      if (!code_rd_n)      ad_in = (i < 6) ? b0 : b1;
      else if (!data_rd_n) ad_in = b0;
      else                 ad_in = 8'hEE;
    end
  endtask

  task automatic ctl_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_addr = a; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic t_reset_entry;
    repeat (20) @(negedge clk);
    check("R11 no reset before threshold", 32'(core_rst), 32'd0);
    repeat (20) @(negedge clk);
    check("R11 reset after long hold", 32'(core_rst), 32'd1);
    check("R12 strobes idle in reset",
          {28'd0, code_rd_n, data_rd_n, data_wr_n, ad_oe}, {28'd0, 4'b1110});
    check("R12 rd_valid low in reset", 32'(rd_valid), 32'd0);
    reset_in = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 reset released", 32'(core_rst), 32'd0);
  endtask

  task automatic t_idle;
    run_cycle(1'b0, 2'd0, 16'h0, 1'b0, 8'h0, 8'h0, 8'h0);
    check("R1 slot_open position", 32'(m_slot), 32'h800);
    check("R2 latch pulses idle", 32'(m_ale), 32'h0C3);
    check("R2 no strobes idle", 32'({m_crd, m_drd, m_dwr, m_oe}), 32'd0);
  endtask

  task automatic t_fetch_ext;
    force_ext_n = 1'b0;
    run_cycle(1'b1, 2'd0, 16'h12FF, 1'b0, 8'h0, 8'h5A, 8'hC3);
    check("R2 latch pulses fetch", 32'(m_ale), 32'h0C3);
    check("R4 code read pulses", 32'(m_crd), 32'h71C);
    check("R4 port enable", 32'(m_oe), 32'h0C3);
    check("R4 low addr first", 32'(ad0), 32'hFF);
    check("R4 low addr second", 32'(ad6), 32'h00);
    check("R4 high addr halves", 32'({hi0, hi6}), 32'h1213);
    check("R5 valid position", 32'(m_val), 32'h800);
    check("R5 fetched bytes", 32'(rdat), 32'hC35A);
    check("R1 slot in fetch", 32'(m_slot), 32'h800);
  endtask

  task automatic t_fetch_internal;
    force_ext_n = 1'b1;
    run_cycle(1'b1, 2'd0, 16'h0100, 1'b0, 8'h0, 8'h11, 8'h22);
    check("R6 internal no code read", 32'(m_crd), 32'd0);
    check("R6 internal no valid", 32'(m_val), 32'd0);
    run_cycle(1'b1, 2'd0, 16'hA000, 1'b0, 8'h0, 8'h33, 8'h44);
    check("R6 high address external", 32'(m_crd), 32'h71C);
    check("R6 high address data", 32'(rdat), 32'h4433);
    force_ext_n = 1'b0;
    run_cycle(1'b1, 2'd0, 16'h0100, 1'b0, 8'h0, 8'h66, 8'h77);
    check("R6 forced external", 32'(rdat), 32'h7766);
  endtask

  task automatic t_data_read;
    run_cycle(1'b1, 2'd2, 16'h8034, 1'b1, 8'h0, 8'h9D, 8'h00);
    check("R3 single latch pulse", 32'(m_ale), 32'h003);
    check("R3 no code read", 32'(m_crd), 32'd0);
    check("R7 data read strobe", 32'(m_drd), 32'h3FC);
    check("R7 port enable", 32'(m_oe), 32'h003);
    check("R7 address low", 32'(ad0), 32'h34);
    check("R7 read result", 32'(rdat), 32'h009D);
    check("R7 valid position", 32'(m_val), 32'h800);
    check("R9 wide high port", 32'({hi0, hi6}), 32'h8080);
    run_cycle(1'b1, 2'd2, 16'h0055, 1'b0, 8'h0, 8'h21, 8'h00);
    check("R9 narrow high port", 32'({hi0, hi6}), 32'hA5A5);
    check("R7 narrow read result", 32'(rdat), 32'h0021);
  endtask

  task automatic t_data_write;
    run_cycle(1'b1, 2'd3, 16'h4321, 1'b1, 8'h3C, 8'h00, 8'h00);
    check("R8 write strobe", 32'(m_dwr), 32'h3F8);
    check("R8 port enable", 32'(m_oe), 32'hFFF);
    check("R8 data during strobe", 32'(wr_bad), 32'd0);
    check("R3 write latch pulse", 32'(m_ale), 32'h003);
    check("R9 write high port", 32'({hi0, hi6}), 32'h4343);
    check("R8 no valid on write", 32'(m_val), 32'd0);
  endtask

  task automatic t_latch_disable;
    ctl_write(8'h8E, 8'h01);
    run_cycle(1'b0, 2'd0, 16'h0, 1'b0, 8'h0, 8'h0, 8'h0);
    check("R10 idle no latch", 32'(m_ale), 32'd0);
    run_cycle(1'b1, 2'd0, 16'h2000, 1'b0, 8'h0, 8'h01, 8'h02);
    check("R10 fetch no latch", 32'(m_ale), 32'd0);
    run_cycle(1'b1, 2'd1, 16'h3000, 1'b0, 8'h0, 8'h0A, 8'h0B);
    check("R10 table keeps latch", 32'(m_ale), 32'h0C3);
    check("R10 table data", 32'(rdat), 32'h0B0A);
    run_cycle(1'b1, 2'd2, 16'h0040, 1'b0, 8'h0, 8'h0C, 8'h00);
    check("R10 data keeps latch", 32'(m_ale), 32'h003);
    ctl_write(8'h8F, 8'h00);
    run_cycle(1'b0, 2'd0, 16'h0, 1'b0, 8'h0, 8'h0, 8'h0);
    check("R10 other address ignored", 32'(m_ale), 32'd0);
    ctl_write(8'h8E, 8'h00);
    run_cycle(1'b0, 2'd0, 16'h0, 1'b0, 8'h0, 8'h0, 8'h0);
    check("R10 cleared restores latch", 32'(m_ale), 32'h0C3);
  endtask

  task automatic t_reset_filter;
    int hi;
    hi = 0;
    @(negedge clk);
    reset_in = 1'b1;
    for (int i = 0; i < 24; i++) begin @(negedge clk); if (core_rst) hi++; end
    reset_in = 1'b0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (core_rst) hi++; end
    check("R11 short pulse ignored", 32'(hi), 32'd0);
    run_cycle(1'b0, 2'd0, 16'h0, 1'b0, 8'h0, 8'h0, 8'h0);
    check("R11 cycle undisturbed", 32'(m_slot), 32'h800);
    ctl_write(8'h8E, 8'h01);
    @(negedge clk);
    reset_in = 1'b1;
    repeat (30) @(negedge clk);
    check("R11 long pulse resets", 32'(core_rst), 32'd1);
    check("R12 port released", 32'(ad_oe), 32'd0);
    reset_in = 1'b0;
    run_cycle(1'b0, 2'd0, 16'h0, 1'b0, 8'h0, 8'h0, 8'h0);
    check("R12 disable bit cleared", 32'(m_ale), 32'h0C3);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset_entry();
    t_idle();
    t_fetch_ext();
    t_fetch_internal();
    t_data_read();
    t_data_write();
    t_latch_disable();
    t_reset_filter();
    finish_up();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end
endmodule